// File: doc/BRIEF.md
# Masked Receive Address Filter

This block decides whether the destination address of an incoming frame belongs to this station. It keeps four byte-wide address registers and two byte-wide mask registers, all loaded over a small write-only register port. A width select picks single-byte or two-byte address comparison. Once the receive path has gathered the address, it pulses a strobe, and one cycle later the filter presents a single accept flag. The flag then holds until the next strobe.

In single-byte mode the received byte is compared with each of the four address registers. The first two registers each have their own mask. The other two are always compared exactly. In two-byte mode the registers pair up as (slot 1, slot 0) and (slot 3, slot 2). The two masks then act together as one 16-bit mask on the first pair only. An address that is all ones is a broadcast, and it is accepted in either mode whatever the registers hold.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset the accept output is 0 and every address and mask register holds zero, so an all-zero address is accepted in both modes until software changes the registers.
- R2: With `wide_mode` = 0, the byte `rx_addr[7:0]` is accepted when it equals any of the four address slots (after masking where R3 applies).
- R3: In single-byte mode, a 1 in mask slot 0 or mask slot 1 makes the matching bit of address slot 0 or slot 1 a don't-care.
- R4: Address slots 2 and 3 are always compared exactly. No mask value affects them.
- R5: With `wide_mode` = 1, `rx_addr[7:0]` is the first-received (low) byte and `rx_addr[15:8]` the high byte. The address is accepted when it equals {slot 1, slot 0} or {slot 3, slot 2}.
- R6: In two-byte mode, {mask slot 1, mask slot 0} forms a 16-bit don't-care mask applied to the {slot 1, slot 0} pair only.
- R7: An all-ones address is always accepted: 0xFF in single-byte mode, 0xFFFF in two-byte mode. In two-byte mode a low byte of 0xFF on its own does not count as all ones.
- R8: `accept` takes the comparison result in the cycle after `addr_done` is sampled high. It keeps that value, whatever the other inputs do, until the next sampled strobe.
- R9: In single-byte mode, `rx_addr[15:8]` has no effect on the result.
- R10: The register port decodes `reg_sel` as follows: 0 to 3 select address slots 0 to 3, 4 selects mask slot 0, and 5 selects mask slot 1. Writes to 6 and 7 change nothing.
- R11: When a register write and an address strobe are sampled on the same edge, that strobe's result uses the register contents from before the write. The new value takes effect from the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write enable |
| reg_sel | input | 3 | Register select (see R10) |
| reg_wdata | input | 8 | Register write data |
| wide_mode | input | 1 | 1 = two-byte addresses, 0 = single-byte |
| rx_addr | input | 16 | Received address; low byte is the first received |
| addr_done | input | 1 | Strobe: address is complete |
| accept | output | 1 | Address accepted, valid one cycle after the strobe |

## Verification
A register write and an address strobe can land on the same clock edge. The open question is then which register contents the comparison sees. The bench provokes this by asserting a write to an address slot together with a strobe whose address only matches the new value. It also does the reverse: a strobe whose address only matches the value being overwritten. The scoreboard model computes each expected result from its register copy before applying the write. It then repeats the same address with a second strobe to confirm that the new value has taken effect.

// File: rtl/af_pkg.sv
package af_pkg;
  localparam int NUM_ADDR = 4;
  localparam int NUM_MASK = 2;
  localparam int SEL_W    = $clog2(NUM_ADDR + NUM_MASK);

  typedef enum logic [SEL_W-1:0] {
    SEL_ADR0 = 3'd0,
    SEL_ADR1 = 3'd1,
    SEL_ADR2 = 3'd2,
    SEL_ADR3 = 3'd3,
    SEL_MSK0 = 3'd4,
    SEL_MSK1 = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/af_regfile.sv
module af_regfile
  import af_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             we,
  input  logic [SEL_W-1:0]                 sel,
  input  logic [BYTE_W-1:0]                wdata,
  output logic [NUM_ADDR-1:0][BYTE_W-1:0]  adr_q,
  output logic [NUM_MASK-1:0][BYTE_W-1:0]  msk_q
);
  localparam int NUM_REGS = NUM_ADDR + NUM_MASK;

  // Unmapped select values; brought out for the checks.
  logic sel_unmapped;
  assign sel_unmapped = (sel >= SEL_W'(NUM_REGS));

  for (genvar a = 0; a < NUM_ADDR; a++) begin : g_adr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          adr_q[a] <= '0;
      else if (we && sel == SEL_W'(a))     adr_q[a] <= wdata;
    end

    AST_ADR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      we && sel == SEL_W'(a) |=> adr_q[a] == $past(wdata));  // R10
  end

  for (genvar m = 0; m < NUM_MASK; m++) begin : g_msk
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 msk_q[m] <= '0;
      else if (we && sel == SEL_W'(NUM_ADDR + m)) msk_q[m] <= wdata;
    end

    AST_MSK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      we && sel == SEL_W'(NUM_ADDR + m) |=> msk_q[m] == $past(wdata));  // R10
  end

  AST_UNMAPPED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    we && sel_unmapped |=> $stable(adr_q) && $stable(msk_q));  // R10
endmodule

// File: rtl/af_match.sv
module af_match
  import af_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                             wide,
  input  logic [2*BYTE_W-1:0]              rx_addr,
  input  logic [NUM_ADDR-1:0][BYTE_W-1:0]  adr_q,
  input  logic [NUM_MASK-1:0][BYTE_W-1:0]  msk_q,
  output logic                             ones_hit,
  output logic                             hit
);
  localparam int PAIR_W    = 2 * BYTE_W;
  localparam int NUM_PAIRS = NUM_ADDR / 2;

  // Equality with don't-care bits: a 1 in msk ignores that bit.
  function automatic logic masked_eq(input logic [PAIR_W-1:0] rx,
                                     input logic [PAIR_W-1:0] ref_v,
                                     input logic [PAIR_W-1:0] msk);
    return ((rx ^ ref_v) & ~msk) == '0;
  endfunction

  logic [NUM_ADDR-1:0]  lane_hit;
  logic [NUM_PAIRS-1:0] pair_hit;
  logic [BYTE_W-1:0]    rx_lo;

  assign rx_lo = rx_addr[BYTE_W-1:0];

  for (genvar i = 0; i < NUM_ADDR; i++) begin : g_lane
    logic [BYTE_W-1:0] lane_msk;
    if (i < NUM_MASK) begin : g_masked
      assign lane_msk = msk_q[i];
    end else begin : g_exact
      assign lane_msk = '0;
    end
    assign lane_hit[i] = masked_eq(PAIR_W'(rx_lo), PAIR_W'(adr_q[i]), PAIR_W'(lane_msk));
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    logic [PAIR_W-1:0] pair_msk;
    if (2 * p + 1 < NUM_MASK) begin : g_masked
      assign pair_msk = {msk_q[2*p+1], msk_q[2*p]};
    end else begin : g_exact
      assign pair_msk = '0;
    end
    assign pair_hit[p] = masked_eq(rx_addr, {adr_q[2*p+1], adr_q[2*p]}, pair_msk);
  end

  assign ones_hit = wide ? (&rx_addr) : (&rx_lo);
  assign hit      = ones_hit | (wide ? (|pair_hit) : (|lane_hit));

  always_comb begin
    if (!wide && rx_lo == adr_q[NUM_ADDR-1]) begin
      AST_EXACT_LANE_HITS: assert (hit);  // R4
    end
  end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import af_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [SEL_W-1:0]    reg_sel,
  input  logic [BYTE_W-1:0]   reg_wdata,
  input  logic                wide_mode,
  input  logic [2*BYTE_W-1:0] rx_addr,
  input  logic                addr_done,
  output logic                accept
);
  logic [NUM_ADDR-1:0][BYTE_W-1:0] adr_q;
  logic [NUM_MASK-1:0][BYTE_W-1:0] msk_q;
  logic match_hit;
  logic match_ones;
  logic accept_q;

  af_regfile #(.BYTE_W(BYTE_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (reg_we),
    .sel   (reg_sel),
    .wdata (reg_wdata),
    .adr_q (adr_q),
    .msk_q (msk_q)
  );

  af_match #(.BYTE_W(BYTE_W)) u_match (
    .wide     (wide_mode),
    .rx_addr  (rx_addr),
    .adr_q    (adr_q),
    .msk_q    (msk_q),
    .ones_hit (match_ones),
    .hit      (match_hit)
  );

  // Result register: loads only on a strobe, holds otherwise.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         accept_q <= 1'b0;
    else if (addr_done) accept_q <= match_hit;
  end

  assign accept = accept_q;

  AST_STROBE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    addr_done |=> accept == $past(match_hit));  // R8
  AST_ACCEPT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_done |=> $stable(accept));  // R8
  AST_BROADCAST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    addr_done && match_ones |=> accept);  // R7
  AST_WRITE_AND_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_done && reg_we |=> accept == $past(match_hit));  // R11
endmodule

// File: tb/sim_rx_addr_filter.sv
`timescale 1ns/1ps
module sim_rx_addr_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [7:0]  reg_wdata = '0;
  logic        wide_mode = 1'b0;
  logic [15:0] rx_addr = '0;
  logic        addr_done = 1'b0;
  logic        accept;

  int vectors = 0;
  int misses = 0;
  bit finished = 0;

  logic [7:0] m_adr [4];
  logic [7:0] m_msk [2];

  bit    exp_q [$];
  string tag_q [$];
  logic [15:0] adr_log [$];

  always #2.5 clk = ~clk;

  rx_addr_filter u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .wide_mode(wide_mode), .rx_addr(rx_addr),
    .addr_done(addr_done), .accept(accept)
  );

  // Reference: bit-by-bit comparison, written independently.
  function automatic bit model(bit wide, logic [15:0] a);
    bit ok;
    if (wide) begin
      logic [15:0] r0, k0, r1;
      if (a == 16'hFFFF) return 1'b1;
      r0 = {m_adr[1], m_adr[0]};
      k0 = {m_msk[1], m_msk[0]};
      r1 = {m_adr[3], m_adr[2]};
      ok = 1'b1;
      for (int b = 0; b < 16; b++) if (!k0[b] && a[b] != r0[b]) ok = 1'b0;
      if (ok) return 1'b1;
      return a == r1;
    end else begin
      if (a[7:0] == 8'hFF) return 1'b1;
      for (int i = 0; i < 4; i++) begin
        logic [7:0] k;
        k = (i < 2) ? m_msk[i] : 8'h00;
        ok = 1'b1;
        for (int b = 0; b < 8; b++) if (!k[b] && a[b] != m_adr[i][b]) ok = 1'b0;
        if (ok) return 1'b1;
      end
      return 1'b0;
    end
  endfunction

  task automatic model_write(logic [2:0] s, logic [7:0] d);
    if (s < 3'd4)       m_adr[s] = d;
    else if (s == 3'd4) m_msk[0] = d;
    else if (s == 3'd5) m_msk[1] = d;
  endtask

  task automatic check(bit got, bit exp, string tag);
    vectors++;
    if (got !== exp) begin
      misses++;
      $display("FAIL %s: accept=%0b expected=%0b", tag, got, exp);
    end
  endtask

  task automatic idle(logic [15:0] a = 16'h0000);
    @(negedge clk);
    reg_we = 0; addr_done = 0; rx_addr = a;
  endtask

  task automatic wr(logic [2:0] s, logic [7:0] d);
    @(negedge clk);
    reg_we = 1; reg_sel = s; reg_wdata = d; addr_done = 0;
    model_write(s, d);
  endtask

  task automatic strobe(bit wide, logic [15:0] a, string tag);
    @(negedge clk);
    reg_we = 0; wide_mode = wide; rx_addr = a; addr_done = 1;
    exp_q.push_back(model(wide, a)); tag_q.push_back(tag); adr_log.push_back(a);
  endtask

  // Write and strobe on the same edge: expectation uses the old contents.
  task automatic strobe_wr(bit wide, logic [15:0] a, logic [2:0] s, logic [7:0] d, string tag);
    @(negedge clk);
    reg_we = 1; reg_sel = s; reg_wdata = d;
    wide_mode = wide; rx_addr = a; addr_done = 1;
    exp_q.push_back(model(wide, a)); tag_q.push_back(tag); adr_log.push_back(a);
    model_write(s, d);
  endtask

  // Monitor: a sampled strobe yields its result by the following negedge.
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && addr_done) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          vectors++; misses++;
          $display("FAIL R8: accept=%0b expected=<none queued>", accept);
        end else begin
          bit e;
          string t;
          logic [15:0] a;
          e = exp_q.pop_front(); t = tag_q.pop_front(); a = adr_log.pop_front();
          vectors++;
          if (accept !== e) begin
            misses++;
            $display("FAIL %s addr=%h: accept=%0b expected=%0b", t, a, accept, e);
          end
        end
      end
    end
  end

  initial begin
    #500000;
    if (!finished) begin
      vectors++; misses++;
      $display("FAIL watchdog: accept=%0b expected=run completion", accept);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) m_adr[i] = 8'h00;
    for (int i = 0; i < 2; i++) m_msk[i] = 8'h00;
    repeat (3) @(negedge clk);
    check(accept, 1'b0, "R1 reset value");
    rst_n = 1;
    strobe(0, 16'h0000, "R1 zero regs 8-bit");
    strobe(1, 16'h0000, "R1 zero regs 16-bit");
    idle();

    wr(3'd0, 8'h12); wr(3'd1, 8'h34); wr(3'd2, 8'h56); wr(3'd3, 8'h78);
    wr(3'd4, 8'h0F); wr(3'd5, 8'h01);
    idle();

    strobe(0, 16'h0056, "R2 slot2");
    strobe(0, 16'h0078, "R2 slot3");
    strobe(0, 16'h0034, "R2 slot1");
    strobe(0, 16'h0099, "R2 no slot");
    strobe(0, 16'h001A, "R3 mask0 low nibble");
    strobe(0, 16'h0022, "R3 mask0 upper bits");
    strobe(0, 16'h0035, "R3 mask1 bit0");
    strobe(0, 16'h0057, "R4 slot2 unmasked");
    strobe(0, 16'h0079, "R4 slot3 unmasked");
    strobe(0, 16'h00FF, "R7 broadcast 8-bit");
    strobe(0, 16'hAB56, "R9 high byte ignored hit");
    strobe(0, 16'h5699, "R9 high byte ignored miss");

    strobe(1, 16'h3412, "R5 pair0");
    strobe(1, 16'h1234, "R5 byte order");
    strobe(1, 16'h7856, "R5 pair1");
    strobe(1, 16'h5678, "R5 pair1 swapped");
    strobe(1, 16'h341F, "R6 pair0 masked low");
    strobe(1, 16'h3512, "R6 pair0 masked high");
    strobe(1, 16'h3612, "R6 pair0 unmasked bit");
    strobe(1, 16'h7857, "R6 pair1 exact");
    strobe(1, 16'hFFFF, "R7 broadcast 16-bit");
    strobe(1, 16'h00FF, "R7 low byte ones only");
    idle();

    // R8: hold after a hit, while the address keeps changing.
    strobe(0, 16'h0056, "R8 load hit");
    idle(16'h0099); check(accept, 1'b1, "R8 hold 1");
    idle(16'h00AA); check(accept, 1'b1, "R8 hold 2");
    strobe(0, 16'h00AA, "R8 load miss");
    wr(3'd3, 8'h99); idle(16'h0099);
    check(accept, 1'b0, "R8 hold after reg change");
    idle(); check(accept, 1'b0, "R8 hold 3");

    // R10: unmapped selects write nothing.
    wr(3'd6, 8'hAA); wr(3'd7, 8'hAA); idle();
    strobe(0, 16'h00AA, "R10 sel6/7 no write");
    strobe(0, 16'h0099, "R10 slot3 written");
    strobe(0, 16'h0012, "R10 slot0 intact");
    wr(3'd4, 8'h00); idle();
    strobe(0, 16'h001A, "R10 mask0 rewritten");

    // R11: write and strobe on the same edge.
    strobe_wr(0, 16'h00AA, 3'd3, 8'hAA, "R11 new value not yet used");
    strobe(0, 16'h00AA, "R11 new value used next");
    strobe_wr(0, 16'h0056, 3'd2, 8'h00, "R11 old value still used");
    strobe(0, 16'h0056, "R11 old value gone");
    idle(); idle();

    wait (exp_q.size() == 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule